// File: doc/BRIEF.md
# Dual-Channel Disk Controller Register File

This block is the memory-mapped control and status register set of a two-channel disk controller. A simple register bus (address, write data, access size, write and read strobes) reaches, for each channel, a DMA command byte, a DMA status byte, a scratch byte, a serial control word, an interrupt-enable half-word and a configuration/status word. Two summary offsets gather both channels' command, interrupt and status bits into single words, so that a driver can poll them in one read.

Each channel takes three live inputs: an interrupt level, a DMA-active flag and a drive-present flag. The block drives back each channel's DMA command bits and a one-cycle bus-reset pulse, and it merges the two channel interrupt flags into one interrupt line. Reads are registered: the word for the address presented with the read strobe appears on the read-data port after the next clock edge and holds until the next read.

Top module: `dcc_regfile`

## Requirements
- R1: After reset every stored field is zero, `irq_out`, `bus_reset` and `dma_cmd` are zero, and the configuration/status words read 0x65150000.
- R2: A write to offset 0x00 (channel 0) or 0x08 (channel 1) stores bits 0 and 3 of `bus_wdata[7:0]` as that channel's command byte. The byte reads back at the same offset and drives `dma_cmd[7:0]` (channel 0) or `dma_cmd[15:8]` (channel 1).
- R3: A write to offset 0x01 or 0x09 stores only bits 5:0 of `bus_wdata[7:0]` as the scratch byte. The upper two bits read back as zero.
- R4: The status byte at 0x02 or 0x0A reads the live DMA-active input at bit 0, keeps bits 5 and 6 as last written, and reads zero at bits 3, 4 and 7. Bit 2 is set on the clock where the channel's interrupt input is high after having been low. Bit 1 is set on the clock where DMA-active is low after having been high. Writing a one to bit 1 or bit 2 clears it, and a setting event wins over a clear in the same cycle.
- R5: Writes to 0x10, 0x11 and 0x12 act exactly like writes to 0x00, 0x01 and 0x02, and writes to 0x18, 0x19 and 0x1A act like writes to 0x08, 0x09 and 0x0A. Of these alias offsets only 0x10 and 0x18 return data on a read.
- R6: A read of 0x10 returns the channel 0 command in bits 7:0 with the channel 0 interrupt flag at bit 4 and the channel 1 interrupt flag at bit 6. Channel 1 status bit 2 appears at bit 14, the channel 0 status in bits 23:16 and the channel 1 status in bits 31:24. A read of 0x18 returns the channel 1 command, its interrupt flag at bit 4 and its status in bits 23:16.
- R7: Each channel's interrupt flag is bit 11 of its configuration/status word (0xA0 for channel 0, 0xE0 for channel 1) and follows the channel's interrupt input with one clock of delay. `irq_out` is the OR of the two flags.
- R8: The serial control word at 0x100 (channel 0) or 0x180 (channel 1) stores bits 11:0 of the write data. A write with bit 0 set raises that channel's `bus_reset` bit for exactly the one clock after the write.
- R9: The interrupt enable at 0x148 (channel 0) or 0x1C8 (channel 1) stores `bus_wdata[31:16]` ANDed with 0x3EED and reads back in bits 31:16.
- R10: Link status at 0x104 (channel 0) or 0x184 (channel 1) reads 0x113 while that channel's drive-present input is high and 0 otherwise.
- R11: The serial control and interrupt-enable words are written only when `bus_size` is 2 (32-bit access); at other sizes the write is ignored. Offsets 0x03, 0x0B and every unmapped offset read zero, and writes to them change nothing.
- R12: `bus_rdata` is loaded on the clock edge where `bus_rd` is high, from the address and state present before that edge, and holds its value while `bus_rd` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 9 | Byte offset of the access |
| bus_wdata | input | 32 | Write data |
| bus_size | input | 2 | Access size: 0 byte, 1 half-word, 2 word |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_rdata | output | 32 | Registered read data |
| irq_in | input | 2 | Per-channel interrupt level |
| dma_active | input | 2 | Per-channel DMA-active flag |
| drive_present | input | 2 | Per-channel drive-present flag |
| bus_reset | output | 2 | Per-channel one-cycle drive bus reset |
| dma_cmd | output | 16 | Channel command bytes, channel 1 in the upper byte |
| irq_out | output | 1 | Combined interrupt |

## Verification
On every cycle the assertions check that the combined interrupt equals the OR of the interrupt inputs one clock earlier, that a bus-reset pulse only follows a 32-bit serial-control write with bit 0 set, that the command outputs hold without a write, that read data holds without a read strobe, and that link status and the reserved offsets return their fixed values. The write-one-to-clear status bits, the set-over-clear priority, the masking of scratch, command and interrupt-enable data, the field packing of the two summary words and the refusal of narrow writes to word registers are shown by the bench's scenarios against its cycle model.

// File: rtl/dcc_pkg.sv
package dcc_pkg;

  localparam int NCH = 2;

  // Offsets derived per channel
  function automatic int a_byte(int ch);
    return ch * 8;
  endfunction

  function automatic int a_cfg(int ch);
    return 160 + ch * 64;
  endfunction

  function automatic int a_sctl(int ch);
    return 256 + ch * 128;
  endfunction

  function automatic int a_link(int ch);
    return a_sctl(ch) + 4;
  endfunction

  function automatic int a_ien(int ch);
    return a_sctl(ch) + 72;
  endfunction

  // Stored status bits 6,5,2,1; bit 0 is supplied live elsewhere
  function automatic logic [7:0] status_next(logic [7:0] cur, logic wr,
                                             logic [7:0] wd, logic set1,
                                             logic set2);
    logic [7:0] r;
    r = 8'h00;
    r[6:5] = wr ? wd[6:5] : cur[6:5];
    r[2:1] = (wr ? (cur[2:1] & ~wd[2:1]) : cur[2:1]) | {set2, set1};
    return r;
  endfunction

  function automatic logic [31:0] cfg_word(logic flag);
    return {16'h6515, 4'h0, flag, 11'h000};
  endfunction

  function automatic logic [31:0] sum0_word(logic [7:0] cmd0, logic f0,
                                            logic f1, logic [7:0] st0,
                                            logic [7:0] st1);
    logic [31:0] w;
    w = {st1, st0, 8'h00, cmd0};
    w[4] = w[4] | f0;
    w[6] = w[6] | f1;
    w[14] = st1[2];
    return w;
  endfunction

  function automatic logic [31:0] sum1_word(logic [7:0] cmd1, logic f1,
                                            logic [7:0] st1);
    logic [31:0] w;
    w = {8'h00, st1, 8'h00, cmd1};
    w[4] = w[4] | f1;
    return w;
  endfunction

endpackage

// File: rtl/dcc_chan.sv
module dcc_chan #(
  parameter int CH       = 0,
  parameter int ADDR_W   = 9,
  parameter int SCTL_W   = 12,
  parameter logic [7:0]  CMD_MASK = 8'h09,
  parameter logic [15:0] IEN_MASK = 16'h3EED
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              word_acc,
  input  logic [ADDR_W-1:0] addr,
  input  logic [31:0]       wdata,
  input  logic              irq_lvl,
  input  logic              dma_act,
  output logic [7:0]        cmd,
  output logic [7:0]        scr,
  output logic [7:0]        status,
  output logic              irq_flag,
  output logic [SCTL_W-1:0] sctl,
  output logic [15:0]       ien,
  output logic              rst_pulse
);
  import dcc_pkg::*;

  localparam logic [ADDR_W-1:0] A_CMD  = ADDR_W'(a_byte(CH));
  localparam logic [ADDR_W-1:0] A_CMDA = ADDR_W'(a_byte(CH) + 16);
  localparam logic [ADDR_W-1:0] A_SCTL = ADDR_W'(a_sctl(CH));
  localparam logic [ADDR_W-1:0] A_IEN  = ADDR_W'(a_ien(CH));

  logic [7:0] st_q;
  logic       act_q;
  logic       hit_cmd, hit_scr, hit_st, hit_sctl, hit_ien;
  logic       ev_irq_rise, ev_dma_end;

  assign hit_cmd  = wr_en && (addr == A_CMD || addr == A_CMDA);
  assign hit_scr  = wr_en && (addr == A_CMD + 1 || addr == A_CMDA + 1);
  assign hit_st   = wr_en && (addr == A_CMD + 2 || addr == A_CMDA + 2);
  assign hit_sctl = wr_en && word_acc && addr == A_SCTL;
  assign hit_ien  = wr_en && word_acc && addr == A_IEN;

  assign ev_irq_rise = irq_lvl && !irq_flag;
  assign ev_dma_end  = !dma_act && act_q;

  assign status = {1'b0, st_q[6:5], 2'b00, st_q[2:1], dma_act};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd       <= 8'h00;
      scr       <= 8'h00;
      st_q      <= 8'h00;
      act_q     <= 1'b0;
      irq_flag  <= 1'b0;
      sctl      <= '0;
      ien       <= 16'h0000;
      rst_pulse <= 1'b0;
    end else begin
      if (hit_cmd) cmd <= wdata[7:0] & CMD_MASK;
      if (hit_scr) scr <= {2'b00, wdata[5:0]};
      st_q      <= status_next(st_q, hit_st, wdata[7:0], ev_dma_end, ev_irq_rise);
      act_q     <= dma_act;
      irq_flag  <= irq_lvl;
      if (hit_sctl) sctl <= wdata[SCTL_W-1:0];
      if (hit_ien) ien <= wdata[31:16] & IEN_MASK;
      rst_pulse <= hit_sctl && wdata[0];
    end
  end
endmodule

// File: rtl/dcc_rdmux.sv
module dcc_rdmux #(
  parameter int ADDR_W = 9,
  parameter int SCTL_W = 12
) (
  input  logic [ADDR_W-1:0]                 addr,
  input  logic [dcc_pkg::NCH-1:0][7:0]      cmd,
  input  logic [dcc_pkg::NCH-1:0][7:0]      scr,
  input  logic [dcc_pkg::NCH-1:0][7:0]      status,
  input  logic [dcc_pkg::NCH-1:0]           flag,
  input  logic [dcc_pkg::NCH-1:0][SCTL_W-1:0] sctl,
  input  logic [dcc_pkg::NCH-1:0][15:0]     ien,
  input  logic [dcc_pkg::NCH-1:0]           drv,
  output logic [31:0]                       data
);
  import dcc_pkg::*;

  localparam logic [ADDR_W-1:0] A_SUM0 = ADDR_W'(16);
  localparam logic [ADDR_W-1:0] A_SUM1 = ADDR_W'(24);
  localparam logic [31:0]       LINK_UP = 32'h0000_0113;

  always_comb begin
    data = 32'h0;
    if (addr == A_SUM0) data = sum0_word(cmd[0], flag[0], flag[1], status[0], status[1]);
    if (addr == A_SUM1) data = sum1_word(cmd[1], flag[1], status[1]);
    for (int ch = 0; ch < NCH; ch++) begin
      if (addr == ADDR_W'(a_byte(ch)))     data = {24'h0, cmd[ch]};
      if (addr == ADDR_W'(a_byte(ch) + 1)) data = {24'h0, scr[ch]};
      if (addr == ADDR_W'(a_byte(ch) + 2)) data = {24'h0, status[ch]};
      if (addr == ADDR_W'(a_cfg(ch)))      data = cfg_word(flag[ch]);
      if (addr == ADDR_W'(a_sctl(ch)))     data = 32'(sctl[ch]);
      if (addr == ADDR_W'(a_link(ch)))     data = drv[ch] ? LINK_UP : 32'h0;
      if (addr == ADDR_W'(a_ien(ch)))      data = {ien[ch], 16'h0000};
    end
  end
endmodule

// File: rtl/dcc_regfile.sv
module dcc_regfile #(
  parameter int ADDR_W = 9,
  parameter int SCTL_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  input  logic [1:0]        bus_size,
  input  logic              bus_wr,
  input  logic              bus_rd,
  output logic [31:0]       bus_rdata,
  input  logic [1:0]        irq_in,
  input  logic [1:0]        dma_active,
  input  logic [1:0]        drive_present,
  output logic [1:0]        bus_reset,
  output logic [15:0]       dma_cmd,
  output logic              irq_out
);
  import dcc_pkg::*;

  localparam logic [1:0] SIZE_WORD = 2'd2;

  logic                        word_acc;
  logic [NCH-1:0][7:0]         cmd, scr, status;
  logic [NCH-1:0]              flag;
  logic [NCH-1:0][SCTL_W-1:0]  sctl;
  logic [NCH-1:0][15:0]        ien;
  logic [31:0]                 rd_next;

  assign word_acc = (bus_size == SIZE_WORD);

  for (genvar ch = 0; ch < NCH; ch++) begin : g_ch
    dcc_chan #(.CH(ch), .ADDR_W(ADDR_W), .SCTL_W(SCTL_W)) u_chan (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_en     (bus_wr),
      .word_acc  (word_acc),
      .addr      (bus_addr),
      .wdata     (bus_wdata),
      .irq_lvl   (irq_in[ch]),
      .dma_act   (dma_active[ch]),
      .cmd       (cmd[ch]),
      .scr       (scr[ch]),
      .status    (status[ch]),
      .irq_flag  (flag[ch]),
      .sctl      (sctl[ch]),
      .ien       (ien[ch]),
      .rst_pulse (bus_reset[ch])
    );
    assign dma_cmd[ch*8 +: 8] = cmd[ch];
  end

  dcc_rdmux #(.ADDR_W(ADDR_W), .SCTL_W(SCTL_W)) u_rdmux (
    .addr   (bus_addr),
    .cmd    (cmd),
    .scr    (scr),
    .status (status),
    .flag   (flag),
    .sctl   (sctl),
    .ien    (ien),
    .drv    (drive_present),
    .data   (rd_next)
  );

  assign irq_out = |flag;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) bus_rdata <= 32'h0;
    else if (bus_rd) bus_rdata <= rd_next;
  end
endmodule

// File: rtl/dcc_regfile_chk.sv
module dcc_regfile_chk #(
  parameter int ADDR_W = 9
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [31:0]       bus_wdata,
  input logic [1:0]        bus_size,
  input logic              bus_wr,
  input logic              bus_rd,
  input logic [31:0]       bus_rdata,
  input logic [1:0]        irq_in,
  input logic [1:0]        drive_present,
  input logic [1:0]        bus_reset,
  input logic [15:0]       dma_cmd,
  input logic              irq_out
);
  logic past_valid;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) past_valid <= 1'b0;
    else past_valid <= 1'b1;
  end

  p_irq_follow_r7: assert property (@(posedge clk) disable iff (!rst_n)
    past_valid |-> (irq_out == $past(|irq_in)));

  p_reset_cause_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (past_valid && bus_reset[0]) |-> $past(bus_wr && bus_size == 2'd2 &&
      bus_addr == ADDR_W'(256) && bus_wdata[0]));

  p_cmd_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (past_valid && !bus_wr) |=> $stable(dma_cmd));

  p_rdata_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (past_valid && !bus_rd) |=> $stable(bus_rdata));

  p_link_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && bus_addr == ADDR_W'(260)) |=>
      (bus_rdata == ($past(drive_present[0]) ? 32'h113 : 32'h0)));

  p_reserved_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && (bus_addr == ADDR_W'(3) || bus_addr == ADDR_W'(11))) |=>
      (bus_rdata == 32'h0));
endmodule

bind dcc_regfile dcc_regfile_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .bus_addr      (bus_addr),
  .bus_wdata     (bus_wdata),
  .bus_size      (bus_size),
  .bus_wr        (bus_wr),
  .bus_rd        (bus_rd),
  .bus_rdata     (bus_rdata),
  .irq_in        (irq_in),
  .drive_present (drive_present),
  .bus_reset     (bus_reset),
  .dma_cmd       (dma_cmd),
  .irq_out       (irq_out)
);

// File: tb/tb_dcc_regfile.sv
`timescale 1ns/1ps
module tb_dcc_regfile;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [8:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [1:0]  bus_size = '0;
  logic        bus_wr = 1'b0, bus_rd = 1'b0;
  logic [31:0] bus_rdata;
  logic [1:0]  irq_in = '0, dma_active = '0, drive_present = '0;
  logic [1:0]  bus_reset;
  logic [15:0] dma_cmd;
  logic        irq_out;

  always #4 clk = ~clk;

  dcc_regfile dut (.*);

  int nchecks = 0, nerr = 0;
  bit cmp_en = 0;
  string cur_tag = "R12";

  // Behavioural reference model
  int unsigned m_cmd[2], m_scr[2], m_s56[2], m_s12[2], m_flag[2];
  int unsigned m_sctl[2], m_ien[2], m_pulse[2], m_pact[2], m_rdata;

  function automatic int unsigned mst(int ch);
    return m_s56[ch] | m_s12[ch] | int'(dma_active[ch]);
  endfunction

  function automatic int unsigned mrd(int unsigned a);
    case (a)
      0:   return m_cmd[0];
      1:   return m_scr[0];
      2:   return mst(0);
      8:   return m_cmd[1];
      9:   return m_scr[1];
      10:  return mst(1);
      16:  return m_cmd[0] | (m_flag[0] << 4) | (m_flag[1] << 6) |
                  (((mst(1) >> 2) & 1) << 14) | (mst(0) << 16) | (mst(1) << 24);
      24:  return m_cmd[1] | (m_flag[1] << 4) | (mst(1) << 16);
      160: return 32'h6515_0000 | (m_flag[0] << 11);
      224: return 32'h6515_0000 | (m_flag[1] << 11);
      256: return m_sctl[0];
      260: return drive_present[0] ? 32'h113 : 0;
      328: return m_ien[0] << 16;
      384: return m_sctl[1];
      388: return drive_present[1] ? 32'h113 : 0;
      456: return m_ien[1] << 16;
      default: return 0;
    endcase
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int c = 0; c < 2; c++) begin
        m_cmd[c] = 0; m_scr[c] = 0; m_s56[c] = 0; m_s12[c] = 0; m_flag[c] = 0;
        m_sctl[c] = 0; m_ien[c] = 0; m_pulse[c] = 0; m_pact[c] = 0;
      end
      m_rdata = 0;
    end else begin
      int unsigned a, d;
      a = bus_addr; d = bus_wdata;
      if (bus_rd) m_rdata = mrd(a);
      for (int c = 0; c < 2; c++) begin
        int unsigned clr, setb;
        clr = 0;
        m_pulse[c] = 0;
        if (bus_wr) begin
          if (a == c*8 || a == c*8 + 16) m_cmd[c] = d & 8'h09;
          if (a == c*8 + 1 || a == c*8 + 17) m_scr[c] = d & 8'h3F;
          if (a == c*8 + 2 || a == c*8 + 18) begin
            m_s56[c] = d & 8'h60;
            clr = d & 8'h06;
          end
          if (bus_size == 2 && a == 256 + c*128) begin
            m_sctl[c] = d & 12'hFFF;
            m_pulse[c] = d & 1;
          end
          if (bus_size == 2 && a == 328 + c*128) m_ien[c] = (d >> 16) & 16'h3EED;
        end
        setb = 0;
        if (irq_in[c] && m_flag[c] == 0) setb |= 4;
        if (!dma_active[c] && m_pact[c] == 1) setb |= 2;
        m_s12[c] = (m_s12[c] & ~clr) | setb;
        m_flag[c] = irq_in[c];
        m_pact[c] = dma_active[c];
      end
    end
  end

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    nchecks++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  // Cycle-by-cycle comparison away from the active edge
  always @(negedge clk) begin
    if (cmp_en) begin
      chk(cur_tag, bus_rdata, m_rdata);
      chk("R7", 32'(irq_out), 32'(m_flag[0] | m_flag[1]));
      chk("R8", 32'(bus_reset), 32'({m_pulse[1][0], m_pulse[0][0]}));
      chk("R2", 32'(dma_cmd), 32'({m_cmd[1][7:0], m_cmd[0][7:0]}));
    end
  end

  task automatic wr(int unsigned a, logic [31:0] d, logic [1:0] sz);
    @(negedge clk);
    bus_wr = 1; bus_addr = a[8:0]; bus_wdata = d; bus_size = sz;
    @(negedge clk);
    bus_wr = 0;
  endtask

  task automatic rd_chk(int unsigned a, logic [31:0] exp, string tag);
    @(negedge clk);
    cur_tag = tag;
    bus_rd = 1; bus_addr = a[8:0];
    @(negedge clk);
    bus_rd = 0;
    chk(tag, bus_rdata, exp);
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  initial begin
    #800000;
    nerr++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("Simulation finished: %0d checks, %0d errors", nchecks, nerr);
    $finish;
  end

  int unsigned alist[22] = '{0, 1, 2, 8, 9, 10, 16, 17, 18, 24, 25, 26,
                             160, 224, 256, 260, 328, 384, 388, 456, 3, 80};

  initial begin
    idle(3);
    rst_n = 1;
    cmp_en = 1;
    // R1 reset state
    chk("R1", 32'({irq_out, bus_reset, dma_cmd}), 32'h0);
    rd_chk(160, 32'h6515_0000, "R1");
    rd_chk(224, 32'h6515_0000, "R1");
    rd_chk(16, 32'h0, "R1");
    // R2 command byte
    wr(0, 32'hFF, 0);
    chk("R2", 32'(dma_cmd), 32'h0009);
    rd_chk(0, 32'h09, "R2");
    // R3 scratch through alias, R5
    wr(25, 32'hFF, 0);
    rd_chk(9, 32'h3F, "R3");
    wr(24, 32'h08, 0);
    chk("R5", 32'(dma_cmd), 32'h0809);
    rd_chk(17, 32'h0, "R5");
    // R4 status events
    @(negedge clk); dma_active[0] = 1;
    @(negedge clk); dma_active[0] = 0;
    @(negedge clk);
    rd_chk(2, 32'h02, "R4");
    irq_in[0] = 1;
    @(negedge clk);
    chk("R7", 32'(irq_out), 32'h1);
    rd_chk(2, 32'h06, "R4");
    rd_chk(160, 32'h6515_0800, "R7");
    wr(18, 32'h64, 0);
    rd_chk(2, 32'h62, "R4");
    dma_active[0] = 1;
    rd_chk(2, 32'h63, "R4");
    // R6 summaries
    rd_chk(16, 32'h0063_0019, "R6");
    irq_in[1] = 1;
    @(negedge clk);
    rd_chk(24, 32'h0004_0018, "R6");
    rd_chk(16, 32'h0463_4059, "R6");
    irq_in[0] = 0;
    idle(2);
    chk("R7", 32'(irq_out), 32'h1);
    irq_in[1] = 0;
    idle(2);
    chk("R7", 32'(irq_out), 32'h0);
    // R8 serial control and reset pulse
    wr(256, 32'hFFFF_F001, 2);
    chk("R8", 32'(bus_reset), 32'h1);
    @(negedge clk);
    chk("R8", 32'(bus_reset), 32'h0);
    rd_chk(256, 32'h001, "R8");
    wr(384, 32'h0000_0FFE, 2);
    chk("R8", 32'(bus_reset), 32'h0);
    rd_chk(384, 32'hFFE, "R8");
    // R11 narrow write to a word register
    wr(256, 32'h0000_0FFF, 0);
    chk("R11", 32'(bus_reset), 32'h0);
    rd_chk(256, 32'h001, "R11");
    // R9 interrupt enable
    wr(328, 32'hFFFF_FFFF, 2);
    rd_chk(328, 32'h3EED_0000, "R9");
    wr(456, 32'h1234_5678, 2);
    rd_chk(456, 32'h1224_0000, "R9");
    wr(456, 32'hFFFF_FFFF, 1);
    rd_chk(456, 32'h1224_0000, "R11");
    // R12 hold
    idle(2);
    chk("R12", bus_rdata, 32'h1224_0000);
    // R10 link status
    drive_present = 2'b01;
    rd_chk(260, 32'h113, "R10");
    rd_chk(388, 32'h0, "R10");
    // R11 unmapped
    wr(3, 32'hFF, 0);
    rd_chk(3, 32'h0, "R11");
    rd_chk(11, 32'h0, "R11");
    wr(80, 32'hFFFF_FFFF, 2);
    rd_chk(80, 32'h0, "R11");
    chk("R11", 32'(dma_cmd), 32'h0809);
    // Mixed traffic checked against the model each cycle
    cur_tag = "R12";
    for (int i = 0; i < 600; i++) begin
      @(negedge clk);
      irq_in = 2'($urandom_range(0, 3));
      dma_active = 2'($urandom_range(0, 3));
      drive_present = 2'($urandom_range(0, 3));
      bus_addr = alist[$urandom_range(0, 21)][8:0];
      bus_wdata = $urandom;
      bus_size = 2'($urandom_range(0, 2));
      bus_wr = ($urandom_range(0, 2) == 0);
      bus_rd = ($urandom_range(0, 1) == 0);
    end
    @(negedge clk);
    bus_wr = 0; bus_rd = 0;
    idle(3);
    $display("Simulation finished: %0d checks, %0d errors", nchecks, nerr);
    $finish;
  end
endmodule